// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit interval timer for a microcontroller-class subsystem. A one-cycle count enable, running at a quarter of the system clock, passes through a selectable prescaler (divide by 1, 4 or 16). Each prescaled tick either advances the counter or, when the counter already equals the programmed period, returns it to zero and signals a match. The match event is sent out unscaled as a single-cycle pulse for use as a PWM time base or a serial shift clock.

A 4-bit postscaler counts match events. When it reaches the selected ratio (1 to 16 matches), it sets a sticky interrupt flag. The interrupt request is this flag gated by an enable bit. Software reaches the counter, the period, the control byte and the interrupt flag/enable through a plain address/write-strobe port with a combinational read path.

Top module: `period_timer`

## Requirements
- R1: After reset, the counter reads 0x00, the period reads 0xFF, the control byte reads 0x00, and the interrupt register reads 0x00 (flag and enable clear). match_pulse and irq_req are low.
- R2: The control field bits 1:0 select the prescale ratio: 00 gives 1:1, 01 gives 1:4, and 10 or 11 gives 1:16. While running, the counter takes one step per that many accepted tick_en cycles.
- R3: On a prescaled tick, the counter moves to 0 if it equals the period and otherwise increments (8-bit wrap). match_pulse is high for exactly the one cycle that follows each clock edge at which the counter moved from the period value to 0.
- R4: With the period at 0x00 and the counter at 0, every prescaled tick is a match and the counter stays at 0.
- R5: The control field bits 6:3 hold a value n. The interrupt flag is set at the same edge as every (n+1)-th match counted since the postscaler was last cleared.
- R6: The interrupt flag stays set until a write to address 3 with data bit 0 equal to 0. irq_req equals the flag AND the enable, where the enable is bit 1 of the last write to address 3.
- R7: If a flag-clearing write happens in the same cycle that a postscaler completion sets the flag, the flag is left set.
- R8: In the control byte, bit 7 always reads 0 and bit 2 is the run bit. While the run bit is 0, the counter and the prescaler hold their contents.
- R9: A write to the counter or to the control byte clears both the prescaler and the postscaler counts, and no count happens in that cycle. A counter write loads the written value.
- R10: The register map is: address 0 is the counter, 1 the period, 2 the control byte, and 3 the interrupt register (bit 0 flag, bit 1 enable, other bits read 0). reg_rdata always shows the register selected by reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable at the instruction rate |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| match_pulse | output | 1 | Unscaled one-cycle period-match pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_req | output | 1 | Interrupt request, flag gated by enable |

## Verification
If the prescaler count is wrong, the counter value read back on address 0 drifts within one prescale period. It also shifts match_pulse by whole ticks. If the postscaler count is off, irq_flag rises one or more matches early or late, which shows up at the very next match. Because every register can be read back on every cycle, a wrong counter, period or flag state appears at reg_rdata in the cycle right after the edge that corrupted it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int DATA_W = 8;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    A_COUNT  = 2'd0,
    A_PERIOD = 2'd1,
    A_CTRL   = 2'd2,
    A_IRQ    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              rsvd;
    logic [POST_W-1:0] post_sel;
    logic              run;
    logic [1:0]        pre_sel;
  } ctrl_t;

  // terminal value of the prescaler count for a given select
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'b00:   lim = PRE_W'(0);
      2'b01:   lim = PRE_W'(3);
      default: lim = PRE_W'(15);
    endcase
    return lim;
  endfunction

  // next counter value on a prescaled tick
  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cnt,
                                                   input logic [DATA_W-1:0] per);
    return (cnt == per) ? '0 : cnt + DATA_W'(1);
  endfunction

  // clear the unimplemented top bit of a control write
  function automatic ctrl_t ctrl_clean(input logic [DATA_W-1:0] d);
    ctrl_t c;
    c      = ctrl_t'(d);
    c.rsvd = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       pre_tick
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] limit;
  logic             accept;

  assign limit    = pre_limit(sel);
  assign accept   = tick_en && run && !clear;
  assign pre_tick = accept && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (clear) begin
      pcnt_q <= '0;
    end else if (accept) begin
      pcnt_q <= (pcnt_q == limit) ? '0 : pcnt_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [CNT_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             match_evt
);

  logic [CNT_W-1:0] count_q;

  assign count     = count_q;
  assign match_evt = pre_tick && (count_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (pre_tick) begin
      count_q <= count_step(count_q, period);
    end
  end

endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_evt,
  input  logic              clear,
  input  logic [POST_W-1:0] sel,
  output logic              flag_set
);

  logic [POST_W-1:0] mcnt_q;
  logic              done;

  assign done     = (mcnt_q == sel);
  assign flag_set = match_evt && !clear && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt_q <= '0;
    end else if (clear) begin
      mcnt_q <= '0;
    end else if (match_evt) begin
      mcnt_q <= done ? '0 : mcnt_q + POST_W'(1);
    end
  end

endmodule

// File: rtl/period_timer.sv
module period_timer
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              match_pulse,
  output logic              irq_flag,
  output logic              irq_req
);

  localparam logic [DATA_W-1:0] PERIOD_RST = {DATA_W{1'b1}};

  // register state
  logic [DATA_W-1:0] period_q;
  ctrl_t             ctrl_q;
  logic              flag_q;
  logic              ien_q;
  logic              match_q;

  // named internal events
  logic              cnt_wr;
  logic              per_wr;
  logic              ctrl_wr;
  logic              irq_wr;
  logic              scaler_clr;
  logic              timer_on;
  logic              pre_tick;
  logic              match_evt;
  logic              flag_set;
  logic [DATA_W-1:0] count_q;

  assign cnt_wr     = reg_wr && (reg_addr == A_COUNT);
  assign per_wr     = reg_wr && (reg_addr == A_PERIOD);
  assign ctrl_wr    = reg_wr && (reg_addr == A_CTRL);
  assign irq_wr     = reg_wr && (reg_addr == A_IRQ);
  assign scaler_clr = cnt_wr || ctrl_wr;
  assign timer_on   = ctrl_q.run;

  ptmr_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run      (timer_on),
    .clear    (scaler_clr),
    .sel      (ctrl_q.pre_sel),
    .pre_tick (pre_tick)
  );

  ptmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_tick  (pre_tick),
    .period    (period_q),
    .load      (cnt_wr),
    .load_val  (reg_wdata),
    .count     (count_q),
    .match_evt (match_evt)
  );

  ptmr_postscaler u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_evt (match_evt),
    .clear     (scaler_clr),
    .sel       (ctrl_q.post_sel),
    .flag_set  (flag_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
      ctrl_q   <= '0;
      ien_q    <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      match_q <= match_evt;
      if (per_wr)  period_q <= reg_wdata;
      if (ctrl_wr) ctrl_q   <= ctrl_clean(reg_wdata);
      if (irq_wr)  ien_q    <= reg_wdata[1];
    end
  end

  // sticky flag: hardware set wins over a same-cycle software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_set) begin
      flag_q <= 1'b1;
    end else if (irq_wr && !reg_wdata[0]) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT:  reg_rdata = count_q;
      A_PERIOD: reg_rdata = period_q;
      A_CTRL:   reg_rdata = ctrl_q;
      default:  reg_rdata = {{(DATA_W-2){1'b0}}, ien_q, flag_q};
    endcase
  end

  assign match_pulse = match_q;
  assign irq_flag    = flag_q;
  assign irq_req     = flag_q && ien_q;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              timer_on,
  input logic              pre_tick,
  input logic              match_evt,
  input logic              flag_set,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic              irq_wr,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] ctrl_byte,
  input logic              match_pulse,
  input logic              irq_flag
);

  assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (tick_en && timer_on));

  assert_match_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_pulse);

  assert_match_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cnt_wr) |=> (count_q == '0));

  assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0 && count_q == '0 && !cnt_wr) |=> (count_q == '0));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_wr) |=> irq_flag);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> irq_flag);

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_on && !cnt_wr && !ctrl_wr) |=> $stable(count_q));

  assert_ctrl_top_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte[DATA_W-1] == 1'b0);

endmodule

bind period_timer ptmr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .timer_on    (timer_on),
  .pre_tick    (pre_tick),
  .match_evt   (match_evt),
  .flag_set    (flag_set),
  .cnt_wr      (cnt_wr),
  .ctrl_wr     (ctrl_wr),
  .irq_wr      (irq_wr),
  .count_q     (count_q),
  .period_q    (period_q),
  .ctrl_byte   (ctrl_q),
  .match_pulse (match_pulse),
  .irq_flag    (irq_flag)
);

// File: tb/period_timer_bench.sv
module period_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       match_pulse;
  logic       irq_flag;
  logic       irq_req;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [7:0] m_cnt, m_per, m_ctrl;
  logic       m_flag, m_en, m_match;
  int         m_pre, m_post;

  always #2 clk = ~clk;

  period_timer u_period_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .match_pulse (match_pulse),
    .irq_flag    (irq_flag),
    .irq_req     (irq_req)
  );

  function automatic int ratio_of(input logic [1:0] sel);
    if (sel == 2'b00) return 1;
    if (sel == 2'b01) return 4;
    return 16;
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_per;
      2'd2: return m_ctrl;
      default: return {6'd0, m_en, m_flag};
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 8'h00; m_per = 8'hFF; m_ctrl = 8'h00;
    m_flag = 1'b0; m_en = 1'b0; m_match = 1'b0;
    m_pre = 0; m_post = 0;
  endtask

  task automatic model_update();
    bit wc, wp, wk, wi, tick, ev, setf;
    wc = reg_wr && reg_addr == 2'd0;
    wp = reg_wr && reg_addr == 2'd1;
    wk = reg_wr && reg_addr == 2'd2;
    wi = reg_wr && reg_addr == 2'd3;
    tick = 0; ev = 0; setf = 0;
    if (wc || wk) begin
      m_pre = 0;
    end else if (m_ctrl[2] && tick_en) begin
      if (m_pre + 1 == ratio_of(m_ctrl[1:0])) begin
        tick = 1; m_pre = 0;
      end else begin
        m_pre = m_pre + 1;
      end
    end
    ev = tick && (m_cnt == m_per);
    if (wc || wk) begin
      m_post = 0;
    end else if (ev) begin
      if (m_post == int'(m_ctrl[6:3])) begin
        setf = 1; m_post = 0;
      end else begin
        m_post = m_post + 1;
      end
    end
    if (wc) m_cnt = reg_wdata;
    else if (ev) m_cnt = 8'h00;
    else if (tick) m_cnt = m_cnt + 8'd1;
    if (setf) m_flag = 1'b1;
    else if (wi && !reg_wdata[0]) m_flag = 1'b0;
    if (wi) m_en = reg_wdata[1];
    if (wp) m_per = reg_wdata;
    if (wk) m_ctrl = {1'b0, reg_wdata[6:0]};
    m_match = ev;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    string rtag;
    case (reg_addr)
      2'd0: rtag = "R2 counter read";
      2'd1: rtag = "R10 period read";
      2'd2: rtag = "R8 control read";
      default: rtag = "R6 irq register read";
    endcase
    chk("R3 match_pulse", {7'd0, match_pulse}, {7'd0, m_match});
    chk("R5 irq_flag", {7'd0, irq_flag}, {7'd0, m_flag});
    chk("R6 irq_req", {7'd0, irq_req}, {7'd0, m_flag & m_en});
    chk(rtag, reg_rdata, model_read(reg_addr));
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rst_n) model_update(); else model_reset();
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick_en = 1'b0;
    cycle();
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) cycle();
    tick_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a);
    reg_addr = a; tick_en = 1'b0;
    cycle();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    for (int i = 0; i < 4; i++) cycle();
    rst_n = 1'b1;

    // R1 / R10: reset values through the register map
    peek(2'd0); chk("R1 counter reset", reg_rdata, 8'h00);
    peek(2'd1); chk("R1 period reset", reg_rdata, 8'hFF);
    peek(2'd2); chk("R1 control reset", reg_rdata, 8'h00);
    peek(2'd3); chk("R10 irq reg reset", reg_rdata, 8'h00);
    chk("R1 irq_req reset", {7'd0, irq_req}, 8'h00);

    // R2: 1:4 prescale, eight enables give two counts
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h05);
    reg_addr = 2'd0;
    ticks(8);
    peek(2'd0); chk("R2 1:4 prescale count", reg_rdata, 8'h02);

    // R4: zero period, every tick matches, counter stays 0
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h04);
    reg_addr = 2'd0; tick_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk("R4 match every tick", {7'd0, match_pulse}, 8'h01);
      chk("R4 counter held at zero", reg_rdata, 8'h00);
    end

    // R7: clear collides with set
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00; tick_en = 1'b1;
    cycle();
    chk("R7 set beats clear", {7'd0, irq_flag}, 8'h01);
    wr_reg(2'd3, 8'h00);
    chk("R6 flag cleared by write", {7'd0, irq_flag}, 8'h00);
    wr_reg(2'd3, 8'h02);
    chk("R6 irq_req low without flag", {7'd0, irq_req}, 8'h00);
    ticks(1);
    chk("R6 irq_req with flag and enable", {7'd0, irq_req}, 8'h01);

    // R8: freeze while stopped, top control bit reads 0
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h10);
    reg_addr = 2'd0;
    ticks(3);
    wr_reg(2'd2, 8'h00);
    reg_addr = 2'd0;
    ticks(5);
    peek(2'd0); chk("R8 counter frozen", reg_rdata, 8'h13);
    wr_reg(2'd2, 8'hFF);
    peek(2'd2); chk("R8 control bit 7 reads 0", reg_rdata, 8'h7F);

    // R9: counter write loads and clears the prescaler
    wr_reg(2'd2, 8'h05);
    ticks(2);
    wr_reg(2'd0, 8'h20);
    chk("R9 counter load", reg_rdata, 8'h20);
    ticks(3);
    peek(2'd0); chk("R9 prescaler cleared", reg_rdata, 8'h20);
    ticks(1);
    peek(2'd0); chk("R9 count after cleared prescale", reg_rdata, 8'h21);

    // R5: postscale 1:3 with zero period at 1:1
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h14);
    ticks(2);
    chk("R5 no flag before third match", {7'd0, irq_flag}, 8'h00);
    ticks(1);
    chk("R5 flag on third match", {7'd0, irq_flag}, 8'h01);

    // constrained random phase, checked every cycle against the model
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 24);
      tick_en = ((i / 1000) % 2 == 1) ? ($urandom % 3 == 0) : (i % 4 == 3);
      if (r == 0) begin
        reg_wr = 1'b1;
        reg_addr = 2'($urandom % 4);
        case (reg_addr)
          2'd0: reg_wdata = 8'($urandom % 8);
          2'd1: reg_wdata = 8'($urandom % 6);
          default: reg_wdata = 8'($urandom);
        endcase
      end else begin
        reg_wr = 1'b0;
        reg_addr = 2'($urandom % 4);
      end
      cycle();
    end
    reg_wr = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule